// File: doc/BRIEF.md
# Timer clock base selector

This block produces the tick that paces a pair of general-purpose timers. The tick is a clock-enable pulse in the domain of a 48 MHz reference clock. A 3-bit base index selects one of seven sources. Three of them run at a fixed rate: 4 MHz, 12 MHz and the full 48 MHz. The other four are 1 MHz, 4 MHz, 12 MHz and 48 MHz, each divided further by an 8-bit divisor in which the code 0 stands for 256. The lower rates are enable pulses formed by dividing the reference by 12, 4 and 48.

The block also guards an interlock with a first event counter (Counter0). The counter's pin is needed by the divided sources, so that counter cannot run while a divided base is in use. One configuration write carries the base index, the divisor and the Counter0 enable together. The block rejects any write whose result would be illegal, and then keeps every setting it had before. The block reports whether Counter0 can be used, whether it is enabled, and whether the most recent write was rejected.

Top module: `tmrclk_base_sel`

## Requirements
- R1: After reset the base is index 2 (undivided 48 MHz): `tick` is high on every reference cycle, `cfg_err` is 0, `cnt0_avail` is 1 and `cnt0_active` is 0.
- R2: Base indices 0, 1 and 2 give one tick every 12, 4 and 1 reference cycles, whatever the value of `cfg_div`.
- R3: Base indices 3, 4, 5 and 6 give one tick every 48·D, 12·D, 4·D and 1·D reference cycles. D is `cfg_div`, except that a `cfg_div` of 0 means D = 256.
- R4: A write with `cfg_base` of 7 is rejected. `cfg_err` becomes 1, and the tick rate and flags stay as they were.
- R5: `cnt0_avail` is 0 exactly while a divided base (index 3 to 6) is selected, and 1 otherwise.
- R6: A write is rejected with `cfg_err` = 1 when it requests a divided base with `cfg_cnt0_en` = 1. This covers enabling Counter0 while a divided base is in force, and selecting a divided base while Counter0 stays enabled.
- R7: A rejected write leaves the base, the divisor and `cnt0_active` unchanged. An accepted write clears `cfg_err` and takes effect from the next source pulse.
- R8: When the tick period is longer than one cycle, `tick` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_base | input | 3 | Requested base index (0 to 6 legal) |
| cfg_div | input | 8 | Divisor for bases 3 to 6; 0 means 256 |
| cfg_cnt0_en | input | 1 | Requested Counter0 enable |
| tick | output | 1 | Timer clock-enable pulse |
| cnt0_avail | output | 1 | Counter0 can be used with the present base |
| cnt0_active | output | 1 | Counter0 is enabled |
| cfg_err | output | 1 | The most recent write was rejected |

## Verification
The error and Counter0 flags are registers, so they change at the same edge that samples `cfg_wr`. The bench reads them at the falling edge that follows the strobe. The tick comes one register after the selected source pulse, and its phase relative to the write depends on the free-running prescalers. For that reason the bench does not pin individual tick edges. After each write it waits more than one full tick period, then counts ticks over a window of exactly four periods, where any phase gives the same count. While the window is open, the monitor also flags two consecutive high ticks whenever the expected period is longer than one cycle.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
   localparam int BASE_W    = 3;
   localparam int NUM_BASES = 7;
   localparam int NUM_SRC   = 4;

   typedef enum logic [1:0] {
      SRC_4M  = 2'd0,
      SRC_12M = 2'd1,
      SRC_48M = 2'd2,
      SRC_1M  = 2'd3
   } src_e;

   localparam logic [BASE_W-1:0] BASE_RESET = 3'd2;
   localparam logic [BASE_W-1:0] BASE_FIRST_DIV = 3'd3;

   function automatic logic base_divided(logic [BASE_W-1:0] b);
      return b >= BASE_FIRST_DIV;
   endfunction

   function automatic logic base_legal(logic [BASE_W-1:0] b);
      return int'(b) < NUM_BASES;
   endfunction

   function automatic src_e base_source(logic [BASE_W-1:0] b);
      case (b)
         3'd0, 3'd4: return SRC_4M;
         3'd1, 3'd5: return SRC_12M;
         3'd3:       return SRC_1M;
         default:    return SRC_48M;
      endcase
   endfunction
endpackage

// File: rtl/tcb_prescale.sv
module tcb_prescale
   import tcb_pkg::*;
#(
   parameter int RATIO_4M  = 12,
   parameter int RATIO_12M = 4,
   parameter int RATIO_1M  = 48
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [NUM_SRC-1:0] src_pulse
);
   function automatic int ratio_of(int idx);
      case (idx)
         0:       return RATIO_4M;
         1:       return RATIO_12M;
         3:       return RATIO_1M;
         default: return 1;
      endcase
   endfunction

   if (RATIO_4M < 1 || RATIO_12M < 1 || RATIO_1M < 1) begin : g_bad_ratio
      $error("tcb_prescale: every ratio must be at least 1");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int R = ratio_of(i);
      if (R == 1) begin : g_full
         assign src_pulse[i] = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(R);
         localparam logic [CW-1:0] LAST = CW'(R - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign src_pulse[i] = (cnt_q == LAST);

         assert_src_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
            src_pulse[i] |=> !src_pulse[i]);
      end
   end
endmodule

// File: rtl/tcb_cfg.sv
module tcb_cfg
   import tcb_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [BASE_W-1:0] cfg_base,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_cnt0_en,
   output logic [BASE_W-1:0] base_q,
   output logic [DIV_W-1:0]  div_q,
   output logic              cnt0_q,
   output logic              err_q,
   output logic              accept,
   output logic              cnt0_avail
);
   logic reject;

   always_comb begin
      reject = !base_legal(cfg_base) ||
               (cfg_cnt0_en && base_divided(cfg_base));
      accept = cfg_wr && !reject;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= BASE_RESET;
         div_q  <= '0;
         cnt0_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (cfg_wr) begin
         err_q <= reject;
         if (!reject) begin
            base_q <= cfg_base;
            div_q  <= cfg_div;
            cnt0_q <= cfg_cnt0_en;
         end
      end
   end

   assign cnt0_avail = !base_divided(base_q);

   assert_base_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(base_q) < NUM_BASES);
   assert_no_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt0_q |-> !base_divided(base_q));
   assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && reject) |=> ($stable(base_q) && $stable(div_q) && $stable(cnt0_q) && err_q));
endmodule

// File: rtl/tcb_tick_div.sv
module tcb_tick_div
   import tcb_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [BASE_W-1:0]  base_q,
   input  logic [DIV_W-1:0]   div_q,
   input  logic [NUM_SRC-1:0] src_pulse,
   output logic               tick
);
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_width
      $error("tcb_tick_div: DIV_W out of range");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;
   logic             pulse;
   logic             divided;

   always_comb begin
      pulse   = src_pulse[base_source(base_q)];
      divided = base_divided(base_q);
      lim     = (div_q == '0) ? {DIV_W{1'b1}} : div_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (!pulse) begin
         tick  <= 1'b0;
      end else if (!divided) begin
         tick  <= 1'b1;
      end else if (cnt_q >= lim) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end

   assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!tick && cnt_q == '0));
   assert_tick_needs_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !$past(restart)) |-> $past(pulse));
endmodule

// File: rtl/tmrclk_base_sel.sv
module tmrclk_base_sel
   import tcb_pkg::*;
#(
   parameter int DIV_W     = 8,
   parameter int RATIO_4M  = 12,
   parameter int RATIO_12M = 4,
   parameter int RATIO_1M  = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [2:0]       cfg_base,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_cnt0_en,
   output logic             tick,
   output logic             cnt0_avail,
   output logic             cnt0_active,
   output logic             cfg_err
);
   logic [BASE_W-1:0]  base_q;
   logic [DIV_W-1:0]   div_q;
   logic               accept;
   logic [NUM_SRC-1:0] src_pulse;

   tcb_prescale #(
      .RATIO_4M (RATIO_4M),
      .RATIO_12M(RATIO_12M),
      .RATIO_1M (RATIO_1M)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_pulse(src_pulse)
   );

   tcb_cfg #(.DIV_W(DIV_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_base   (cfg_base),
      .cfg_div    (cfg_div),
      .cfg_cnt0_en(cfg_cnt0_en),
      .base_q     (base_q),
      .div_q      (div_q),
      .cnt0_q     (cnt0_active),
      .err_q      (cfg_err),
      .accept     (accept),
      .cnt0_avail (cnt0_avail)
   );

   tcb_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (accept),
      .base_q   (base_q),
      .div_q    (div_q),
      .src_pulse(src_pulse),
      .tick     (tick)
   );

   assert_active_avail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt0_active |-> cnt0_avail);
endmodule

// File: tb/tmrclk_base_sel_tb.sv
module tmrclk_base_sel_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_base = 3'd0;
   logic [7:0] cfg_div = 8'd0;
   logic       cfg_cnt0_en = 1'b0;
   logic       tick, cnt0_avail, cnt0_active, cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int    exp;
      int    per;
      string tag;
   } item_t;
   item_t exp_q[$];

   logic win = 1'b0;
   logic win_d = 1'b0;
   logic prev_tick = 1'b0;
   int   cnt = 0;
   int   dbl = 0;

   always #2 clk = ~clk;

   tmrclk_base_sel u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
      .cfg_div(cfg_div), .cfg_cnt0_en(cfg_cnt0_en), .tick(tick),
      .cnt0_avail(cnt0_avail), .cnt0_active(cnt0_active), .cfg_err(cfg_err)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: counts ticks in the window, compares at window close
   always @(negedge clk) begin
      if (win) begin
         cnt = cnt + int'(tick);
         if (tick && prev_tick && exp_q.size() > 0 && exp_q[0].per > 1) dbl++;
      end
      if (win_d && !win && exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         chk({it.tag, " tick count"}, cnt, it.exp);
         if (it.per > 1) chk("R8 no back-to-back ticks", dbl, 0);
         cnt = 0;
         dbl = 0;
      end
      prev_tick = tick;
      win_d     = win;
   end

   task automatic wr(int b, int d, bit c0);
      @(negedge clk);
      cfg_base    = 3'(b);
      cfg_div     = 8'(d);
      cfg_cnt0_en = c0;
      cfg_wr      = 1'b1;
      @(negedge clk);
      cfg_wr      = 1'b0;
   endtask

   task automatic measure(int per, string tag);
      item_t it;
      repeat (per + 4) @(posedge clk);
      it.exp = 4;
      it.per = per;
      it.tag = tag;
      exp_q.push_back(it);
      win <= 1'b1;
      repeat (4 * per) @(posedge clk);
      win <= 1'b0;
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset cfg_err", int'(cfg_err), 0);
      chk("R1 reset cnt0_avail", int'(cnt0_avail), 1);
      chk("R1 reset cnt0_active", int'(cnt0_active), 0);
      measure(1, "R1 reset base 48MHz");

      // fixed bases: divisor ignored
      wr(0, 7, 0);   measure(12, "R2 base0 div7");
      wr(1, 0, 0);   measure(4, "R2 base1 div0");
      chk("R5 fixed base avail", int'(cnt0_avail), 1);
      wr(2, 200, 0); measure(1, "R2 base2 div200");

      // divided bases
      wr(3, 1, 0);   measure(48, "R3 base3 div1");
      chk("R5 divided base avail", int'(cnt0_avail), 0);
      wr(3, 0, 0);   measure(12288, "R3 base3 div0=256");
      wr(4, 5, 0);   measure(60, "R3 base4 div5");
      wr(5, 0, 0);   measure(1024, "R3 base5 div0=256");
      wr(6, 3, 0);   measure(3, "R3 base6 div3");
      wr(6, 1, 0);   measure(1, "R3 base6 div1");
      wr(5, 255, 0); measure(1020, "R3 base5 div255");

      // illegal index
      wr(7, 9, 0);
      chk("R4 index7 cfg_err", int'(cfg_err), 1);
      chk("R7 index7 avail kept", int'(cnt0_avail), 0);
      measure(1020, "R4 R7 index7 rate kept");

      // accepted Counter0 enable on a fixed base
      wr(2, 0, 1);
      chk("R7 accept clears cfg_err", int'(cfg_err), 0);
      chk("R5 cnt0_active set", int'(cnt0_active), 1);
      chk("R5 avail with fixed base", int'(cnt0_avail), 1);

      // divided base while Counter0 stays enabled
      wr(4, 2, 1);
      chk("R6 divided base with cnt0 cfg_err", int'(cfg_err), 1);
      chk("R7 cnt0_active kept", int'(cnt0_active), 1);
      chk("R7 avail kept", int'(cnt0_avail), 1);
      measure(1, "R7 rejected divided base rate kept");

      // enabling Counter0 while a divided base is in force
      wr(3, 1, 0);
      chk("R7 accept clears cfg_err again", int'(cfg_err), 0);
      chk("R5 cnt0 off after divided", int'(cnt0_active), 0);
      wr(3, 1, 1);
      chk("R6 enable cnt0 on divided cfg_err", int'(cfg_err), 1);
      chk("R7 cnt0 stays off", int'(cnt0_active), 0);
      measure(48, "R7 rejected cnt0 rate kept");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule